// File: doc/BRIEF.md
# Colour E-Paper Panel Command Sequencer

This block sits on the host side of a colour e-paper panel and drives the panel's controller over a four-wire SPI link. A separate data/command select pin, a hardware reset pin and a busy input go with the link. One start request makes the block run the whole update: a hardware reset and the power-on initialisation, an identity check of the controller, the transfer of one packed frame from a byte stream, a refresh command, and then a wait for the panel to report ready. The block ends every run with a one-cycle completion pulse and a set of status flags.

The panel-setting command is always the first transfer after any reset. The block remembers whether the controller has been initialised since its last reset, so later updates skip straight to the frame transfer. In timed-abort mode the refresh is cut short a set number of cycles after it starts by pulsing the reset pin. This leaves the panel in an intermediate optical state and marks the controller as uninitialised. A busy timeout also marks the controller as uninitialised, so the next start runs the full reset and initialisation again.

Top module: `epd_cmd_seq`

## Requirements
- R1: On a start while the controller is uninitialised, epd_rst_n goes low for RST_LOW_CYC cycles and then high for RST_REL_CYC cycles. Chip-select stays high while reset is low. The first byte sent after the pulse is command 0x00, carrying data bytes 0x5F then 0xE9.
- R2: Initialisation continues in a fixed order. Command 0x01 carries data 0x3F, 0x00. Command 0x06 carries data 0x6F, 0x1F, 0x17. Command 0x30 carries one data byte. The block waits for the panel to be ready after 0x01 and after 0x06.
- R3: The data byte of command 0x30 is PLL_CFG, which defaults to 0x08. The value 0x07 is rejected when the design is elaborated and is never sent.
- R4: After 0x30, the block sends command 0xCD followed by one dummy data byte 0x00. During that data byte it reads a byte on epd_miso, MSB first, on the rising edges of SCK. If the byte read is not ID_EXPECT (0x04), id_err is set.
- R5: The frame transfer is command 0x10 followed by FRAME_BYTES bytes, taken in order from the pix_data/pix_valid/pix_ready stream. A byte is accepted in any cycle where pix_valid and pix_ready are both high. Chip-select stays low for the whole transfer, including stalls where pix_valid is low.
- R6: After the frame, the block sends the single command byte 0x12 and waits for the panel to be ready. It then pulses done high for exactly one cycle.
- R7: A start while the controller is initialised produces no reset pulse and no initialisation bytes. The run begins directly with command 0x10.
- R8: The panel is ready when epd_busy is low after at least BUSY_GUARD cycles of waiting. If epd_busy stays high for BUSY_TIMEOUT cycles, timeout_err is set, done is pulsed and the controller is marked uninitialised.
- R9: If abort_en is high at start, abort_dly is latched. When the refresh wait reaches abort_dly cycles, epd_rst_n is driven low for RST_LOW_CYC cycles, aborted is set and done is pulsed. The next start then runs the full reset and initialisation. If busy releases first, the refresh completes normally with aborted low.
- R10: SPI uses mode 0. Data changes while SCK is low and is sampled on the rising edge. epd_dc is low for command bytes and high for data bytes, and it does not change while SCK is high. Chip-select goes high between commands. SCK is low whenever chip-select is high.
- R11: Out of reset, epd_cs_n=1, epd_sck=0, epd_rst_n=1, done=0, pix_ready=0 and all flags are 0. Every start clears timeout_err, id_err and aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts one update run; taken only while idle |
| abort_en | input | 1 | Selects timed abort for this run |
| abort_dly | input | TMR_W | Refresh cycles before the abort reset |
| pix_data | input | 8 | Packed pixel byte, two 4-bit pixels |
| pix_valid | input | 1 | pix_data holds a byte |
| pix_ready | output | 1 | Block takes pix_data this cycle if pix_valid is high |
| epd_sck | output | 1 | SPI clock |
| epd_mosi | output | 1 | SPI data to the panel |
| epd_miso | input | 1 | SPI data from the panel, used for the identity read |
| epd_cs_n | output | 1 | Chip-select, active low |
| epd_dc | output | 1 | 0 = command byte, 1 = data byte |
| epd_rst_n | output | 1 | Panel hardware reset, active low |
| epd_busy | input | 1 | High while the panel is busy |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout_err | output | 1 | Busy wait timed out in the last run |
| id_err | output | 1 | Identity byte did not match in the last run |
| aborted | output | 1 | Last refresh was cut short by the timed abort |

## Verification
The bench goes after ordering. If a design let any other byte ahead of the panel-setting command, or reordered the initialisation, the byte scoreboard would flag it at once. If a design skipped the re-initialisation after an abort or a timeout, it would send 0x10 with no reset pulse, and both the reset-edge count and the expected byte queue would show it. If a design dropped chip-select during a stalled pixel stream, a byte would turn up flagged as the start of a new transfer. The bench also checks how the abort races the busy release. It measures the distance from the end of 0x12 to the reset edge, and it checks that a busy release arriving first leaves aborted clear. A mismatched identity byte must raise id_err, and the next matching read must clear it.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

   typedef enum logic [2:0] {
      ST_PSR, ST_PWR, ST_BST, ST_PLL, ST_ID, ST_DTM, ST_DRF
   } step_e;

   typedef enum logic [3:0] {
      F_IDLE, F_RST_LO, F_RST_HI, F_CMD, F_CMD_W, F_DAT, F_DAT_W,
      F_GAP, F_BUSY, F_ABRT, F_FIN
   } fsm_e;

   function automatic logic [7:0] step_cmd(step_e s);
      case (s)
         ST_PSR:  return 8'h00;
         ST_PWR:  return 8'h01;
         ST_BST:  return 8'h06;
         ST_PLL:  return 8'h30;
         ST_ID:   return 8'hCD;
         ST_DTM:  return 8'h10;
         default: return 8'h12;
      endcase
   endfunction

   // number of fixed data bytes; the frame step length comes from a parameter
   function automatic int unsigned fixed_len(step_e s);
      case (s)
         ST_PSR:  return 2;
         ST_PWR:  return 2;
         ST_BST:  return 3;
         ST_PLL:  return 1;
         ST_ID:   return 1;
         default: return 0;
      endcase
   endfunction

   function automatic logic step_waits(step_e s);
      return (s == ST_PWR) || (s == ST_BST) || (s == ST_DRF);
   endfunction

   function automatic logic [7:0] step_data(step_e s, logic [2:0] i, logic [7:0] pll);
      case (s)
         ST_PSR:  return (i == 3'd0) ? 8'h5F : 8'hE9;
         ST_PWR:  return (i == 3'd0) ? 8'h3F : 8'h00;
         ST_BST:  return (i == 3'd0) ? 8'h6F : ((i == 3'd1) ? 8'h1F : 8'h17);
         ST_PLL:  return pll;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/epd_spi_tx.sv
module epd_spi_tx #(
   parameter int HALF = 2
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       go,
   input  logic [7:0] din,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       busy,
   output logic       done,
   output logic [7:0] dout
);
   localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

   logic       act, ph, done_q, tick;
   logic [2:0] bitn;
   logic [7:0] sh, rx;

   generate
      if (HALF == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [DW-1:0] div;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)                   div <= '0;
            else if (!act || tick)         div <= '0;
            else                           div <= div + 1'b1;
         end
         assign tick = (div == DW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         act <= 1'b0; ph <= 1'b0; bitn <= '0;
         sh <= '0; rx <= '0; done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!act) begin
            if (go) begin
               act <= 1'b1; sh <= din; ph <= 1'b0; bitn <= '0;
            end
         end else if (tick) begin
            if (!ph) begin
               ph <= 1'b1;
               rx <= {rx[6:0], miso};
            end else begin
               ph <= 1'b0;
               sh <= {sh[6:0], 1'b0};
               if (bitn == 3'd7) begin
                  act    <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bitn <= bitn + 3'd1;
               end
            end
         end
      end
   end

   assign sck  = ph;
   assign mosi = sh[7];
   assign busy = act;
   assign done = done_q;
   assign dout = rx;
endmodule

// File: rtl/epd_tick_cnt.sv
module epd_tick_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         run,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)          cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt != '1)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/epd_cmd_seq.sv
module epd_cmd_seq
   import epd_seq_pkg::*;
#(
   parameter int         SCK_HALF     = 2,
   parameter int         FRAME_BYTES  = 192000,
   parameter int         RST_LOW_CYC  = 400,
   parameter int         RST_REL_CYC  = 400,
   parameter int         BUSY_GUARD   = 8,
   parameter int         BUSY_TIMEOUT = 1200000000,
   parameter int         TMR_W        = 32,
   parameter logic [7:0] PLL_CFG      = 8'h08,
   parameter logic [7:0] ID_EXPECT    = 8'h04
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             start,
   input  logic             abort_en,
   input  logic [TMR_W-1:0] abort_dly,
   input  logic [7:0]       pix_data,
   input  logic             pix_valid,
   output logic             pix_ready,
   output logic             epd_sck,
   output logic             epd_mosi,
   input  logic             epd_miso,
   output logic             epd_cs_n,
   output logic             epd_dc,
   output logic             epd_rst_n,
   input  logic             epd_busy,
   output logic             done,
   output logic             timeout_err,
   output logic             id_err,
   output logic             aborted
);
   localparam int LEN_RAW = $clog2(FRAME_BYTES + 1);
   localparam int LEN_W   = (LEN_RAW > 3) ? LEN_RAW : 3;

   generate
      if (PLL_CFG == 8'h07) begin : g_bad_pll
         $error("PLL_CFG 0x07 doubles the panel clock");
      end
      if (SCK_HALF < 1 || FRAME_BYTES < 1 || RST_LOW_CYC < 1 || RST_REL_CYC < 1) begin : g_bad_cnt
         $error("timing and frame parameters must be positive");
      end
      if (BUSY_GUARD >= BUSY_TIMEOUT) begin : g_bad_guard
         $error("busy guard must be shorter than the busy timeout");
      end
   endgenerate

   fsm_e             st;
   step_e            step;
   logic [LEN_W-1:0] idx, cur_len;
   logic             inited, abort_q;
   logic [TMR_W-1:0] dly_q, cnt;
   logic             tx_go, tx_busy, tx_done, byte_avail, last_step, ready;
   logic [7:0]       tx_byte, rx_byte;
   logic             run;

   assign cur_len    = (step == ST_DTM) ? LEN_W'(FRAME_BYTES) : LEN_W'(fixed_len(step));
   assign byte_avail = (step != ST_DTM) || pix_valid;
   assign last_step  = (step == ST_DRF);
   assign run        = (st == F_RST_LO) || (st == F_RST_HI) || (st == F_BUSY) || (st == F_ABRT);
   assign ready      = (cnt >= TMR_W'(BUSY_GUARD)) && !epd_busy;

   assign tx_go   = (st == F_CMD) || ((st == F_DAT) && byte_avail);
   assign tx_byte = (st == F_CMD)    ? step_cmd(step) :
                    (step == ST_DTM) ? pix_data : step_data(step, idx[2:0], PLL_CFG);

   epd_spi_tx #(.HALF(SCK_HALF)) u_spi (
      .clk(clk), .arst_n(arst_n), .go(tx_go), .din(tx_byte), .miso(epd_miso),
      .sck(epd_sck), .mosi(epd_mosi), .busy(tx_busy), .done(tx_done), .dout(rx_byte)
   );

   epd_tick_cnt #(.W(TMR_W)) u_tmr (
      .clk(clk), .arst_n(arst_n), .run(run), .cnt(cnt)
   );

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st <= F_IDLE; step <= ST_PSR; idx <= '0; inited <= 1'b0;
         abort_q <= 1'b0; dly_q <= '0;
         timeout_err <= 1'b0; id_err <= 1'b0; aborted <= 1'b0;
      end else begin
         case (st)
            F_IDLE: if (start) begin
               abort_q <= abort_en; dly_q <= abort_dly;
               timeout_err <= 1'b0; id_err <= 1'b0; aborted <= 1'b0;
               if (inited) begin step <= ST_DTM; st <= F_CMD; end
               else        st <= F_RST_LO;
            end
            F_RST_LO: if (cnt == TMR_W'(RST_LOW_CYC - 1)) st <= F_RST_HI;
            F_RST_HI: if (cnt == TMR_W'(RST_LOW_CYC + RST_REL_CYC - 1)) begin
               step <= ST_PSR; st <= F_CMD;
            end
            F_CMD: st <= F_CMD_W;
            F_CMD_W: if (tx_done) begin
               idx <= '0;
               st  <= (cur_len != '0) ? F_DAT : F_GAP;
            end
            F_DAT: if (byte_avail) st <= F_DAT_W;
            F_DAT_W: if (tx_done) begin
               if (step == ST_ID) id_err <= (rx_byte != ID_EXPECT);
               if (idx == cur_len - 1'b1) st <= F_GAP;
               else begin idx <= idx + 1'b1; st <= F_DAT; end
            end
            F_GAP: begin
               if (step_waits(step))  st <= F_BUSY;
               else if (last_step)    st <= F_FIN;
               else begin
                  if (step == ST_ID) inited <= 1'b1;
                  step <= step_e'(step + 3'd1);
                  st   <= F_CMD;
               end
            end
            F_BUSY: begin
               if (last_step && abort_q && cnt == dly_q) begin
                  inited <= 1'b0; aborted <= 1'b1; st <= F_ABRT;
               end else if (ready) begin
                  if (last_step) st <= F_FIN;
                  else begin step <= step_e'(step + 3'd1); st <= F_CMD; end
               end else if (cnt == TMR_W'(BUSY_TIMEOUT - 1)) begin
                  timeout_err <= 1'b1; inited <= 1'b0; st <= F_FIN;
               end
            end
            F_ABRT: if (cnt == dly_q + TMR_W'(RST_LOW_CYC)) st <= F_FIN;
            F_FIN:  st <= F_IDLE;
            default: st <= F_IDLE;
         endcase
      end
   end

   assign epd_cs_n  = !((st == F_CMD) || (st == F_CMD_W) || (st == F_DAT) || (st == F_DAT_W));
   assign epd_dc    = (st == F_DAT) || (st == F_DAT_W);
   assign epd_rst_n = !((st == F_RST_LO) || (st == F_ABRT));
   assign pix_ready = (st == F_DAT) && (step == ST_DTM);
   assign done      = (st == F_FIN);

endmodule

// File: rtl/epd_cmd_seq_chk.sv
module epd_cmd_seq_chk #(
   parameter logic [7:0] PLL_CFG = 8'h08
) (
   input logic clk,
   input logic arst_n,
   input logic sck,
   input logic mosi,
   input logic cs_n,
   input logic dc,
   input logic rst_n,
   input logic done
);
   logic       sck_q, byte_ev, byte_dc, after_rst, pll_seen;
   logic [2:0] bits;
   logic [7:0] sh, byte_val, last_cmd;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         sck_q <= 1'b0; bits <= '0; sh <= '0; byte_ev <= 1'b0;
         byte_val <= '0; byte_dc <= 1'b0;
      end else begin
         sck_q   <= sck;
         byte_ev <= 1'b0;
         if (cs_n) bits <= '0;
         else if (sck && !sck_q) begin
            sh   <= {sh[6:0], mosi};
            bits <= bits + 3'd1;
            if (bits == 3'd7) begin
               byte_ev  <= 1'b1;
               byte_val <= {sh[6:0], mosi};
               byte_dc  <= dc;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         after_rst <= 1'b0; pll_seen <= 1'b0; last_cmd <= 8'hFF;
      end else if (!rst_n) begin
         after_rst <= 1'b1; pll_seen <= 1'b0;
      end else if (byte_ev && !byte_dc) begin
         after_rst <= 1'b0;
         last_cmd  <= byte_val;
         if (byte_val == 8'h30) pll_seen <= 1'b1;
      end
   end

   assert_first_cmd_psr_R1: assert property (@(posedge clk) disable iff (!arst_n)
      (byte_ev && !byte_dc && after_rst) |-> (byte_val == 8'h00));
   assert_no_xfer_in_reset_R1: assert property (@(posedge clk) disable iff (!arst_n)
      !rst_n |-> cs_n);
   assert_pll_value_R3: assert property (@(posedge clk) disable iff (!arst_n)
      (byte_ev && byte_dc && last_cmd == 8'h30) |-> (byte_val != 8'h07 && byte_val == PLL_CFG));
   assert_refresh_after_init_R9: assert property (@(posedge clk) disable iff (!arst_n)
      (byte_ev && !byte_dc && byte_val == 8'h12) |-> pll_seen);
   assert_sck_idle_R10: assert property (@(posedge clk) disable iff (!arst_n)
      cs_n |-> !sck);
   assert_dc_stable_R10: assert property (@(posedge clk) disable iff (!arst_n)
      (sck && sck_q) |-> $stable(dc));
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!arst_n)
      done |=> !done);

endmodule

bind epd_cmd_seq epd_cmd_seq_chk #(.PLL_CFG(PLL_CFG)) u_chk (
   .clk(clk), .arst_n(arst_n), .sck(epd_sck), .mosi(epd_mosi), .cs_n(epd_cs_n),
   .dc(epd_dc), .rst_n(epd_rst_n), .done(done)
);

// File: tb/sim_epd_cmd_seq.sv
module sim_epd_cmd_seq;
   localparam int TW = 16;
   localparam int FB = 6;

   logic          clk = 1'b0;
   logic          arst_n = 1'b0;
   logic          start = 1'b0, abort_en = 1'b0;
   logic [TW-1:0] abort_dly = '0;
   logic [7:0]    pix_data = '0;
   logic          pix_valid = 1'b0;
   logic          pix_ready, epd_sck, epd_mosi, epd_cs_n, epd_dc, epd_rst_n;
   logic          epd_miso, epd_busy = 1'b0;
   logic          done, timeout_err, id_err, aborted;

   always #10 clk = ~clk;

   epd_cmd_seq #(
      .SCK_HALF(2), .FRAME_BYTES(FB), .RST_LOW_CYC(10), .RST_REL_CYC(12),
      .BUSY_GUARD(4), .BUSY_TIMEOUT(200), .TMR_W(TW)
   ) u0 (
      .clk(clk), .arst_n(arst_n), .start(start), .abort_en(abort_en), .abort_dly(abort_dly),
      .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .epd_sck(epd_sck), .epd_mosi(epd_mosi), .epd_miso(epd_miso), .epd_cs_n(epd_cs_n),
      .epd_dc(epd_dc), .epd_rst_n(epd_rst_n), .epd_busy(epd_busy), .done(done),
      .timeout_err(timeout_err), .id_err(id_err), .aborted(aborted)
   );

   int compared = 0, mismatched = 0;
   logic [9:0] exp_q[$];

   // panel model state
   logic [7:0] id_val = 8'h04, id_sh = '0, sh = '0, last_cmd = 8'hFF, seed_v = '0;
   int  init_busy = 12, drf_busy = 30, busy_left = 0, bitc = 0, k = 0;
   int  rst_falls = 0, cyc = 0, drf_cs_t = 0, rst_fall_t = 0;
   logic sck_p = 1'b0, cs_p = 1'b1, rst_p = 1'b1, win_first = 1'b0, acc_pend = 1'b0, gaps = 1'b0;

   assign epd_miso = id_sh[7];

   function automatic logic [7:0] pat(logic [7:0] s, int n);
      return 8'(s + 8'(n) * 8'd29);
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic score(input logic first, input logic dc, input logic [7:0] b);
      logic [9:0] e;
      if (exp_q.size() == 0) begin
         check(1'b0, "R5/R7 unexpected byte", {first, dc, b}, 0);
      end else begin
         e = exp_q.pop_front();
         check(e == {first, dc, b}, "R1/R2/R4/R5/R6/R10 scoreboard", {first, dc, b}, e);
      end
   endtask

   // monitor, panel model and pixel source
   always @(negedge clk) begin
      cyc++;
      if (rst_p && !epd_rst_n) begin rst_falls++; rst_fall_t = cyc; end
      if (cs_p && !epd_cs_n) begin win_first = 1'b1; bitc = 0; end
      if (!cs_p && epd_cs_n) begin
         if (last_cmd == 8'h01 || last_cmd == 8'h06) busy_left = init_busy;
         if (last_cmd == 8'h12) begin busy_left = drf_busy; drf_cs_t = cyc; end
      end
      if (!epd_cs_n && epd_sck && !sck_p) begin
         sh    = {sh[6:0], epd_mosi};
         id_sh = {id_sh[6:0], 1'b0};
         bitc++;
         if (bitc == 8) begin
            bitc = 0;
            score(win_first, epd_dc, sh);
            win_first = 1'b0;
            if (!epd_dc) begin
               last_cmd = sh;
               if (sh == 8'hCD) id_sh = id_val;
            end
         end
      end
      if (!epd_rst_n) busy_left = 0;
      else if (busy_left > 0) busy_left--;
      epd_busy = (busy_left > 0);
      if (start) k = 0;
      else if (acc_pend) k++;
      pix_data  = pat(seed_v, k);
      pix_valid = gaps ? (cyc % 3 != 0) : 1'b1;
      acc_pend  = pix_ready && pix_valid;
      sck_p = epd_sck; cs_p = epd_cs_n; rst_p = epd_rst_n;
   end

   task automatic push(input logic f, input logic d, input logic [7:0] b);
      exp_q.push_back({f, d, b});
   endtask

   task automatic push_init();
      push(1, 0, 8'h00); push(0, 1, 8'h5F); push(0, 1, 8'hE9);
      push(1, 0, 8'h01); push(0, 1, 8'h3F); push(0, 1, 8'h00);
      push(1, 0, 8'h06); push(0, 1, 8'h6F); push(0, 1, 8'h1F); push(0, 1, 8'h17);
      push(1, 0, 8'h30); push(0, 1, 8'h08);
      push(1, 0, 8'hCD); push(0, 1, 8'h00);
   endtask

   task automatic push_frame(input logic [7:0] s);
      push(1, 0, 8'h10);
      for (int i = 0; i < FB; i++) push(0, 1, pat(s, i));
      push(1, 0, 8'h12);
   endtask

   task automatic run(input logic ab, input int dly, input logic need_init,
                      input logic [7:0] s, input logic g);
      int w;
      seed_v = s; gaps = g;
      if (need_init) push_init();
      push_frame(s);
      @(negedge clk); #2; abort_en = ab; abort_dly = TW'(dly); start = 1'b1;
      @(negedge clk); #2; start = 1'b0;
      w = 0;
      while (!done && w < 20000) begin @(negedge clk); w++; end
      check(w < 20000, "R6 done reached", w, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(epd_cs_n && !epd_sck && epd_rst_n && !done && !pix_ready, "R11 reset outputs",
            {epd_cs_n, epd_sck, epd_rst_n, done, pix_ready}, 5'b10100);
      check(!timeout_err && !id_err && !aborted, "R11 reset flags",
            {timeout_err, id_err, aborted}, 0);
      #2 arst_n = 1'b1;
      repeat (3) @(negedge clk);

      // first run: reset, init, frame, refresh
      run(0, 0, 1, 8'h11, 0);
      check(exp_q.size() == 0, "R1 R2 R4 R5 R6 all bytes seen", exp_q.size(), 0);
      check(rst_falls == 1, "R1 one reset pulse", rst_falls, 1);
      check({timeout_err, id_err, aborted} == 3'b000, "R4 R6 flags clean",
            {timeout_err, id_err, aborted}, 0);
      @(negedge clk);
      check(!done, "R6 done one cycle", done, 0);

      // already initialised, stalled stream
      run(0, 0, 0, 8'h5A, 1);
      check(exp_q.size() == 0, "R5 R7 frame only with stalls", exp_q.size(), 0);
      check(rst_falls == 1, "R7 no reset when initialised", rst_falls, 1);

      // timed abort during refresh
      drf_busy = 150;
      run(1, 40, 0, 8'h23, 0);
      check(aborted == 1'b1, "R9 aborted set", aborted, 1);
      check(rst_falls == 2, "R9 abort reset pulse", rst_falls, 2);
      check((rst_fall_t - drf_cs_t) >= 41 && (rst_fall_t - drf_cs_t) <= 43,
            "R9 abort delay", rst_fall_t - drf_cs_t, 42);
      check(exp_q.size() == 0, "R9 bytes before abort", exp_q.size(), 0);

      // after abort: full re-init, wrong identity
      drf_busy = 20; id_val = 8'h3C;
      run(0, 0, 1, 8'h77, 0);
      check(rst_falls == 3, "R9 re-init reset after abort", rst_falls, 3);
      check(exp_q.size() == 0, "R9 init bytes after abort", exp_q.size(), 0);
      check(id_err == 1'b1, "R4 identity mismatch flag", id_err, 1);
      check(aborted == 1'b0, "R11 aborted cleared at start", aborted, 0);

      // busy timeout during refresh
      drf_busy = 400; id_val = 8'h04;
      run(0, 0, 0, 8'h02, 0);
      check(timeout_err == 1'b1, "R8 timeout flag", timeout_err, 1);
      check(id_err == 1'b0, "R11 id_err cleared at start", id_err, 0);

      // after timeout: re-init
      drf_busy = 20;
      run(0, 0, 1, 8'hC4, 0);
      check(rst_falls == 4, "R8 re-init after timeout", rst_falls, 4);
      check(exp_q.size() == 0, "R8 init bytes after timeout", exp_q.size(), 0);
      check({timeout_err, id_err} == 2'b00, "R4 R11 flags clear", {timeout_err, id_err}, 0);

      // abort armed but busy releases first
      run(1, 100, 0, 8'h9E, 0);
      check(aborted == 1'b0, "R9 busy release beats abort", aborted, 0);
      check(rst_falls == 4, "R9 no reset without abort", rst_falls, 4);
      check(exp_q.size() == 0, "R6 normal refresh bytes", exp_q.size(), 0);

      repeat (5) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule